// File: doc/BRIEF.md
# Burst Read Block Mover

The block copies a run of 32-bit words from a memory that it reads with bursts into an on-chip buffer that it writes one word per transfer. A controller loads a source byte address, a destination byte address and a word count, then pulses `go`. The engine splits the run into read bursts and sends them on a pipelined read master that uses an address, a burst count, a read strobe, a wait request and a read-data-valid qualifier. The returned words go into an internal FIFO built on a plain memory array. A separate write side drains that FIFO into the destination, one word per accepted write.

The read side and the write side run independently. Either one can stall without stalling the other until the FIFO limits it. A burst is sent only when the FIFO has space reserved for every word of that burst, so the read side never has to refuse returned data. When the final word has been written the engine raises `done` for a single cycle and goes back to idle. Transfers are always whole words, so both addresses advance in steps of four bytes.

Top module: `blk_burst_mover`

## Requirements
- R1: A `go` pulse while idle captures `src_addr`, `dst_addr` and `len_words` and raises `busy`. A `go` pulse while `busy` is high changes neither the transfer in progress nor its addresses.
- R2: Read bursts start at the captured source address. Write addresses start at the captured destination address. Each address advances by 4 per word.
- R3: Every burst count is the smaller of the words not yet requested and `MAX_BURST`, and it is never zero.
- R4: While `rd_read` is high and `rd_waitrequest` is high, `rd_read`, `rd_addr` and `rd_burstcount` hold their values into the next cycle.
- R5: A burst is issued only when the FIFO has free entries for all of its words. The FIFO count never exceeds its depth, and at most FIFO depth + 1 words are ever requested but not yet written.
- R6: The words written to the destination equal the words returned by the read side, in the same order, and their number equals the captured length.
- R7: While `wr_write` is high and `wr_waitrequest` is high, `wr_write`, `wr_addr` and `wr_writedata` hold their values into the next cycle.
- R8: `done` is high for exactly one cycle. It is the cycle after the clock edge that accepts the last write. `busy` is low in that cycle.
- R9: A length of zero issues no read and no write, and `done` pulses in the cycle after `go` is accepted. While idle, `rd_read` and `wr_write` stay low.
- R10: The length input is 9 bits wide, so the longest run is 511 words. That run completes correctly across many bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, honoured only while idle |
| src_addr | input | AW | Source byte address, word aligned |
| dst_addr | input | AW | Destination byte address, word aligned |
| len_words | input | LEN_W | Number of 32-bit words to move |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | output | AW | Read burst start address |
| rd_burstcount | output | BC_W | Words in the current burst |
| rd_read | output | 1 | Read burst request |
| rd_waitrequest | input | 1 | Read side not ready to accept the request |
| rd_readdata | input | DW | Returned read word |
| rd_readdatavalid | input | 1 | `rd_readdata` is valid |
| wr_addr | output | AW | Destination word address |
| wr_writedata | output | DW | Destination write data |
| wr_write | output | 1 | Write request |
| wr_waitrequest | input | 1 | Destination not ready to accept the write |

## Verification
The assertions take four things for granted about the read side. It returns exactly the number of words each accepted burst asked for. It never raises `rd_readdatavalid` before that burst's request has been accepted. It returns data in request order. The controller pulses `go` with a length that fits the counter. The bench's memory model meets these conditions by construction. It queues each burst in the same cycle the request is accepted, and it answers only from bursts queued at earlier edges. Its random wait-request and data-valid gaps vary in density from vector to vector, and they never create or drop a word.

// File: rtl/bm_pkg.sv
package bm_pkg;
  // byte address step per 32-bit word, as a shift amount
  localparam int WORD_SHIFT = 2;

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/bm_rst_sync.sv
module bm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/bm_fifo.sv
module bm_fifo #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 512,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    din,
  input  logic             pop,
  output logic [DW-1:0]    q,
  output logic [CNT_W-1:0] count
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    q_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (push) wptr_d = (32'(wptr_q) == DEPTH - 1) ? '0 : wptr_q + PTR_W'(1);
    if (pop)  rptr_d = (32'(rptr_q) == DEPTH - 1) ? '0 : rptr_q + PTR_W'(1);
    cnt_d = cnt_q + (push ? CNT_W'(1) : '0) - (pop ? CNT_W'(1) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // storage and its registered read port, no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop) q_q <= mem[rptr_q];
  end

  assign q     = q_q;
  assign count = cnt_q;
endmodule

// File: rtl/bm_rd_ctl.sv
module bm_rd_ctl
  import bm_pkg::*;
#(
  parameter  int AW        = 32,
  parameter  int LEN_W     = 9,
  parameter  int MAX_BURST = 512,
  parameter  int DEPTH     = 512,
  localparam int BC_W      = $clog2(MAX_BURST + 1),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    src,
  input  logic [LEN_W-1:0] len,
  input  logic [CNT_W-1:0] fifo_count,
  output logic [AW-1:0]    rd_addr,
  output logic [BC_W-1:0]  rd_burstcount,
  output logic             rd_read,
  input  logic             rd_waitrequest,
  input  logic             rd_readdatavalid
);
  logic [AW-1:0]    addr_q, addr_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [BC_W-1:0]  bc_q, bc_d;
  logic             read_q, read_d;
  logic [CNT_W-1:0] pend_q, pend_d;
  int unsigned      want, room;
  logic             accept, launch;

  always_comb begin
    want   = min_u(32'(left_q), 32'(MAX_BURST));
    room   = 32'(DEPTH) - 32'(fifo_count) - 32'(pend_q);
    accept = read_q && !rd_waitrequest;
    launch = !read_q && (left_q != '0) && (room >= want);

    addr_d = addr_q;
    left_d = left_q;
    bc_d   = bc_q;
    read_d = read_q;
    if (start) begin
      addr_d = src;
      left_d = len;
    end
    if (accept) begin
      read_d = 1'b0;
      left_d = left_q - LEN_W'(bc_q);
      addr_d = addr_q + (AW'(bc_q) << WORD_SHIFT);
    end
    if (launch) begin
      read_d = 1'b1;
      bc_d   = BC_W'(want);
    end
    pend_d = pend_q + (accept ? CNT_W'(bc_q) : '0)
                    - (rd_readdatavalid ? CNT_W'(1) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
      bc_q   <= '0;
      read_q <= 1'b0;
      pend_q <= '0;
    end else begin
      addr_q <= addr_d;
      left_q <= left_d;
      bc_q   <= bc_d;
      read_q <= read_d;
      pend_q <= pend_d;
    end
  end

  assign rd_addr       = addr_q;
  assign rd_burstcount = bc_q;
  assign rd_read       = read_q;
endmodule

// File: rtl/bm_wr_ctl.sv
module bm_wr_ctl
  import bm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    dst,
  input  logic [LEN_W-1:0] len,
  input  logic             fifo_empty,
  output logic             pop,
  output logic [AW-1:0]    wr_addr,
  output logic             wr_write,
  input  logic             wr_waitrequest,
  output logic             fin,
  output logic             done
);
  logic             valid_q, valid_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             done_q;
  logic             accept;

  always_comb begin
    accept  = valid_q && !wr_waitrequest;
    pop     = !fifo_empty && (!valid_q || !wr_waitrequest);
    valid_d = pop || (valid_q && wr_waitrequest);

    addr_d = addr_q;
    left_d = left_q;
    if (start) begin
      addr_d = dst;
      left_d = len;
    end else if (accept) begin
      addr_d = addr_q + (AW'(1) << WORD_SHIFT);
      left_d = left_q - LEN_W'(1);
    end
    fin = (start && (len == '0)) || (accept && (left_q == LEN_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      done_q  <= fin;
    end
  end

  assign wr_addr  = addr_q;
  assign wr_write = valid_q;
  assign done     = done_q;
endmodule

// File: rtl/blk_burst_mover.sv
module blk_burst_mover #(
  parameter  int AW         = 32,
  parameter  int DW         = 32,
  parameter  int LEN_W      = 9,
  parameter  int MAX_BURST  = 512,
  parameter  int FIFO_DEPTH = 512,
  localparam int BC_W       = $clog2(MAX_BURST + 1),
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [AW-1:0]    src_addr,
  input  logic [AW-1:0]    dst_addr,
  input  logic [LEN_W-1:0] len_words,
  output logic             busy,
  output logic             done,
  output logic [AW-1:0]    rd_addr,
  output logic [BC_W-1:0]  rd_burstcount,
  output logic             rd_read,
  input  logic             rd_waitrequest,
  input  logic [DW-1:0]    rd_readdata,
  input  logic             rd_readdatavalid,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_writedata,
  output logic             wr_write,
  input  logic             wr_waitrequest
);
  logic             rst_n_i;
  logic             busy_q, busy_d;
  logic             start, fin, pop;
  logic [CNT_W-1:0] fifo_count;

  bm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  always_comb begin
    start  = go && !busy_q;
    busy_d = busy_q;
    if (fin)        busy_d = 1'b0;
    else if (start) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) busy_q <= 1'b0;
    else          busy_q <= busy_d;
  end

  bm_rd_ctl #(
    .AW(AW), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .DEPTH(FIFO_DEPTH)
  ) u_rd (
    .clk              (clk),
    .rst_n            (rst_n_i),
    .start            (start),
    .src              (src_addr),
    .len              (len_words),
    .fifo_count       (fifo_count),
    .rd_addr          (rd_addr),
    .rd_burstcount    (rd_burstcount),
    .rd_read          (rd_read),
    .rd_waitrequest   (rd_waitrequest),
    .rd_readdatavalid (rd_readdatavalid)
  );

  bm_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n_i),
    .push  (rd_readdatavalid),
    .din   (rd_readdata),
    .pop   (pop),
    .q     (wr_writedata),
    .count (fifo_count)
  );

  bm_wr_ctl #(.AW(AW), .LEN_W(LEN_W)) u_wr (
    .clk            (clk),
    .rst_n          (rst_n_i),
    .start          (start),
    .dst            (dst_addr),
    .len            (len_words),
    .fifo_empty     (fifo_count == '0),
    .pop            (pop),
    .wr_addr        (wr_addr),
    .wr_write       (wr_write),
    .wr_waitrequest (wr_waitrequest),
    .fin            (fin),
    .done           (done)
  );

  assign busy = busy_q;
endmodule

// File: rtl/bm_check.sv
module bm_check #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int MAX_BURST = 512,
  parameter int DEPTH     = 512,
  parameter int BC_W      = 10,
  parameter int CNT_W     = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             busy,
  input logic             done,
  input logic             rd_read,
  input logic             rd_waitrequest,
  input logic [AW-1:0]    rd_addr,
  input logic [BC_W-1:0]  rd_burstcount,
  input logic             wr_write,
  input logic             wr_waitrequest,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_writedata,
  input logic [CNT_W-1:0] fifo_count
);
  p_go_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> (busy || done));

  p_burst_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_read |-> ((rd_burstcount != '0) && (32'(rd_burstcount) <= MAX_BURST)));

  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_read && rd_waitrequest) |=>
      (rd_read && $stable(rd_addr) && $stable(rd_burstcount)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_count) <= DEPTH);

  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_write && wr_waitrequest) |=>
      (wr_write && $stable(wr_addr) && $stable(wr_writedata)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_read && !wr_write));
endmodule

bind blk_burst_mover bm_check #(
  .AW(AW), .DW(DW), .MAX_BURST(MAX_BURST), .DEPTH(FIFO_DEPTH),
  .BC_W(BC_W), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .go             (go),
  .busy           (busy),
  .done           (done),
  .rd_read        (rd_read),
  .rd_waitrequest (rd_waitrequest),
  .rd_addr        (rd_addr),
  .rd_burstcount  (rd_burstcount),
  .wr_write       (wr_write),
  .wr_waitrequest (wr_waitrequest),
  .wr_addr        (wr_addr),
  .wr_writedata   (wr_writedata),
  .fifo_count     (fifo_count)
);

// File: tb/sim_blk_burst_mover.sv
module sim_blk_burst_mover;
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int LEN_W = 9;
  localparam int MAXB  = 8;
  localparam int DEPTH = 16;
  localparam int BC_W  = $clog2(MAXB + 1);

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [8:0]  len;
    logic [6:0]  rpct;
    logic [6:0]  wpct;
    logic        mid_go;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 32'h0000_8000, 9'd5,   7'd0,  7'd0,  1'b0},
    '{32'h0000_2000, 32'h0000_9000, 9'd8,   7'd30, 7'd0,  1'b0},
    '{32'h0000_3000, 32'h0000_A000, 9'd37,  7'd40, 7'd40, 1'b0},
    '{32'h0000_4000, 32'h0000_B000, 9'd64,  7'd0,  7'd70, 1'b0},
    '{32'h0000_5000, 32'h0000_C000, 9'd100, 7'd50, 7'd20, 1'b1},
    '{32'h0000_7FFC, 32'h0000_D000, 9'd1,   7'd20, 7'd20, 1'b0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n, go;
  logic [AW-1:0]    src_addr, dst_addr;
  logic [LEN_W-1:0] len_words;
  logic             busy, done;
  logic [AW-1:0]    rd_addr;
  logic [BC_W-1:0]  rd_burstcount;
  logic             rd_read;
  logic             rd_waitrequest = 1'b0;
  logic [DW-1:0]    rd_readdata = '0;
  logic             rd_readdatavalid = 1'b0;
  logic [AW-1:0]    wr_addr;
  logic [DW-1:0]    wr_writedata;
  logic             wr_write;
  logic             wr_waitrequest = 1'b0;

  blk_burst_mover #(
    .AW(AW), .DW(DW), .LEN_W(LEN_W), .MAX_BURST(MAXB), .FIFO_DEPTH(DEPTH)
  ) u0 (.*);

  int checks = 0;
  int errors = 0;

  int          rpct = 0, wpct = 0;
  logic [31:0] exp_src, exp_raddr, exp_waddr;
  int          rd_left_exp = 0, wr_cnt = 0, req_cnt = 0;
  logic [31:0] bq_addr [128];
  int          bq_cnt  [128];
  int          bq_head = 0, bq_tail = 0, boff = 0;
  int          cyc = 0, last_wr_cyc = 0;

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model on the read side, buffer model on the write side
  always @(negedge clk) begin
    cyc++;
    if (bq_head != bq_tail && 32'($urandom % 100) >= rpct) begin
      rd_readdatavalid = 1'b1;
      rd_readdata      = mdata(bq_addr[bq_head] + 32'(boff * 4));
      boff++;
      if (boff == bq_cnt[bq_head]) begin
        boff = 0;
        bq_head++;
      end
    end else begin
      rd_readdatavalid = 1'b0;
      rd_readdata      = '0;
    end

    wr_waitrequest = 32'($urandom % 100) < wpct;
    if (wr_write && !wr_waitrequest) begin
      check(wr_addr == exp_waddr, "R2 write address", wr_addr, exp_waddr);
      check(wr_writedata == mdata(exp_src + 32'(wr_cnt * 4)), "R6 write data order",
            wr_writedata, mdata(exp_src + 32'(wr_cnt * 4)));
      wr_cnt++;
      exp_waddr   = exp_waddr + 32'd4;
      last_wr_cyc = cyc;
    end

    rd_waitrequest = 32'($urandom % 100) < rpct;
    if (rd_read && !rd_waitrequest) begin
      int exp_bc;
      exp_bc = (rd_left_exp < MAXB) ? rd_left_exp : MAXB;
      check(rd_addr == exp_raddr, "R2 read address", rd_addr, exp_raddr);
      check(32'(rd_burstcount) == 32'(exp_bc), "R3 burst count",
            32'(rd_burstcount), 32'(exp_bc));
      bq_addr[bq_tail] = rd_addr;
      bq_cnt[bq_tail]  = int'(rd_burstcount);
      bq_tail++;
      exp_raddr   = exp_raddr + 32'(exp_bc * 4);
      rd_left_exp = rd_left_exp - exp_bc;
      req_cnt     = req_cnt + int'(rd_burstcount);
      check(req_cnt - wr_cnt <= DEPTH + 1, "R5 words in flight",
            32'(req_cnt - wr_cnt), 32'(DEPTH + 1));
    end
  end

  task automatic run(input vec_t v, input string name);
    int n;
    int go_cyc;
    @(negedge clk); #1;
    rpct = int'(v.rpct);  wpct = int'(v.wpct);
    exp_src = v.src;  exp_raddr = v.src;  exp_waddr = v.dst;
    rd_left_exp = int'(v.len);
    wr_cnt = 0;  req_cnt = 0;  bq_head = 0;  bq_tail = 0;  boff = 0;
    src_addr = v.src;  dst_addr = v.dst;  len_words = v.len;
    go = 1'b1;  go_cyc = cyc;
    @(negedge clk); #1;
    go = 1'b0;
    if (v.mid_go) begin
      repeat (4) @(negedge clk);
      #1;
      check(busy, "R1 busy during run", 32'(busy), 32'd1);
      src_addr = 32'hDEAD_0000;  dst_addr = 32'hBEEF_0000;  len_words = 9'd3;
      go = 1'b1;
      @(negedge clk); #1;
      go = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk); #1;
      n++;
    end
    if (!done) begin
      checks++;  errors++;
      $display("FAIL R8 %s timeout actual=0 expected=1", name);
    end else begin
      if (v.len == 0)
        check(cyc == go_cyc + 1, "R9 done cycle after go", 32'(cyc), 32'(go_cyc + 1));
      else
        check(cyc == last_wr_cyc + 1, "R8 done cycle after last write",
              32'(cyc), 32'(last_wr_cyc + 1));
      check(!busy, "R8 busy low with done", 32'(busy), 32'd0);
      check(wr_cnt == int'(v.len), "R6 words written", 32'(wr_cnt), 32'(v.len));
      @(negedge clk); #1;
      check(!done, "R8 done single cycle", 32'(done), 32'd0);
      repeat (10) @(negedge clk);
      #1;
      check(req_cnt == int'(v.len), "R1 no extra reads", 32'(req_cnt), 32'(v.len));
      check(wr_cnt == int'(v.len), "R1 no extra writes", 32'(wr_cnt), 32'(v.len));
    end
  endtask

  initial begin
    #2_000_000;
    checks++;  errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;  go = 1'b0;
    src_addr = '0;  dst_addr = '0;  len_words = '0;
    exp_src = '0;  exp_raddr = '0;  exp_waddr = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !rd_read && !wr_write, "R9 reset state idle",
          {28'd0, busy, done, rd_read, wr_write}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!busy && !rd_read && !wr_write, "R9 idle after reset",
          {29'd0, busy, rd_read, wr_write}, 32'd0);

    for (int i = 0; i < NV; i++) run(VECS[i], "vector");

    // R9: empty transfer
    run('{32'h0000_6000, 32'h0000_E000, 9'd0, 7'd10, 7'd10, 1'b0}, "zero length");
    // R10: longest run the 9-bit count allows, with stalls on both sides
    run('{32'h0001_0000, 32'h0002_0000, 9'd511, 7'd25, 7'd25, 1'b0}, "max length");
    // R5: write side heavily stalled so the FIFO must throttle bursts
    run('{32'h0003_0000, 32'h0004_0000, 9'd90, 7'd0, 7'd90, 1'b0}, "fifo pressure");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule